// File: doc/BRIEF.md
# SDRAM Data Bus Latency Controller

This block sits on the controller side of a synchronous DRAM interface and decides, cycle by cycle, when the shared data bus carries valid read data, when the memory is expected to be driving the bus, and when write data is taken. It watches the commands the controller issues: read, write, data-mask level, bank deactivate, chip-select and clock-enable. From them it derives three strobes that keep the fixed cycle offsets the memory imposes.

Read data appears a number of edges after the read command that depends on the programmed CAS latency (2 or 3). Write data is taken in the same cycle as the write command. The data-mask input has an asymmetric latency: it blocks write data in the cycle it is raised, but it only blocks read data two edges later. After a deactivate the memory releases the bus after a number of edges equal to the CAS latency. Bursts have a parameterised length, and a new read or write command cuts short the burst in progress. When clock-enable is low, the internal state freezes one edge later.

Top module: `dbl_bus_timer`

## Requirements
- R1: A read sampled at edge E0 with `cas_lat3_i`=0 (CAS latency 2) makes `rd_valid_o` and `bus_drive_o` high after edges E1..E(BURST_LEN); with `cas_lat3_i`=1 (CAS latency 3) they are high after edges E2..E(BURST_LEN+1). Both are low otherwise.
- R2: `wr_take_o` is high in the same cycle as an accepted write command and in the following BURST_LEN-1 cycles.
- R3: `mask_i` high blocks `wr_take_o` in that same cycle (zero-cycle write mask).
- R4: `mask_i` high at edge Em clears `rd_valid_o` only after edge Em+2. `bus_drive_o` is unaffected, and `rd_valid_o` is never high without `bus_drive_o`.
- R5: A deactivate sampled at edge Ed ends any read burst: `bus_drive_o` and `rd_valid_o` are low from edge Ed+2 (CAS latency 2) or Ed+3 (CAS latency 3).
- R6: A new read restarts the read burst at its own latency, and the earlier burst runs until that point. A write clears any read burst or pending read at its own edge.
- R7: A read or deactivate accepted in a cycle ends a write burst, and `wr_take_o` is low from that cycle on.
- R8: With `cs_i` low, the read, write and deactivate inputs are ignored in that same cycle.
- R9: `cke_i` low at edge Ec freezes all state at edge Ec+1. While frozen, outputs hold, commands are ignored and `wr_take_o` is low.
- R10: During reset all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cas_lat3_i | input | 1 | CAS latency select: 0 = 2, 1 = 3 |
| cke_i | input | 1 | Clock enable as issued to the memory |
| cs_i | input | 1 | Chip select; command inputs are valid only when high |
| rd_cmd_i | input | 1 | Read command issued |
| wr_cmd_i | input | 1 | Write command issued |
| deact_cmd_i | input | 1 | Bank deactivate (single or all) issued |
| mask_i | input | 1 | Data mask level, high = mask |
| rd_valid_o | output | 1 | Read data beat valid on the bus this cycle |
| bus_drive_o | output | 1 | Memory expected to drive the data bus |
| wr_take_o | output | 1 | Write data beat taken this cycle |

## Verification
Plain reads at both CAS latencies separate the latency 2 and latency 3 start edges. Masked reads and writes show the two-cycle versus zero-cycle mask offset: a mask applied at the wrong offset lands on a different beat. Deactivates at each latency, and a second read issued inside a burst, separate the release timing from the truncation rule. Chip-select low, and a clock-enable pulse in the middle of a burst, show that commands are gated in the same cycle while the internal clock stops one cycle late, which stretches the burst by exactly one beat.

// File: rtl/dbl_pkg.sv
package dbl_pkg;
    // highest supported CAS latency
    localparam int CL_MAX      = 3;
    // output data mask delay in edges
    localparam int RD_MASK_LAT = 2;

    function automatic int cnt_width(input int beats);
        return (beats > 1) ? $clog2(beats) : 1;
    endfunction
endpackage

// File: rtl/dbl_delay.sv
module dbl_delay #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic clr_i,
    input  logic din_i,
    input  logic sel_long_i,
    output logic tap_o
);
    typedef struct packed {
        logic [DEPTH-1:0] stage;
    } dly_t;

    dly_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_i) begin
            if (clr_i) st_d.stage = '0;
            else       st_d.stage = {st_q.stage[DEPTH-2:0], din_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // long tap = last stage, short tap = one before it
    assign tap_o = sel_long_i ? st_q.stage[DEPTH-1] : st_q.stage[DEPTH-2];
endmodule

// File: rtl/dbl_burst.sv
module dbl_burst #(
    parameter int LW   = 2,
    parameter int MAXV = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          load_i,
    input  logic [LW-1:0] load_val_i,
    input  logic          clr_i,
    output logic          active_o
);
    typedef struct packed {
        logic          active;
        logic [LW-1:0] left;
    } bst_t;

    bst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_i) begin
            if (load_i) begin
                st_d.active = 1'b1;
                st_d.left   = load_val_i;
            end else if (clr_i) begin
                st_d.active = 1'b0;
                st_d.left   = '0;
            end else if (st_q.active) begin
                if (st_q.left == '0) st_d.active = 1'b0;
                else                 st_d.left   = st_q.left - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o = st_q.active;

    AST_LEFT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |-> (int'(st_q.left) <= MAXV)); // R1
    AST_LAST_BEAT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && en_i && !load_i && !clr_i && st_q.left == '0) |=> !active_o); // R1
endmodule

// File: rtl/dbl_bus_timer.sv
module dbl_bus_timer #(
    parameter int BURST_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cas_lat3_i,
    input  logic cke_i,
    input  logic cs_i,
    input  logic rd_cmd_i,
    input  logic wr_cmd_i,
    input  logic deact_cmd_i,
    input  logic mask_i,
    output logic rd_valid_o,
    output logic bus_drive_o,
    output logic wr_take_o
);
    import dbl_pkg::*;

    localparam int LW = cnt_width(BURST_LEN);
    localparam logic [LW-1:0] RD_LOAD = LW'(BURST_LEN - 1);
    localparam logic [LW-1:0] WR_LOAD = LW'((BURST_LEN > 1) ? BURST_LEN - 2 : 0);
    localparam logic MULTI_BEAT = (BURST_LEN > 1);

    typedef struct packed {
        logic cke;
    } top_t;

    top_t st_d, st_q;

    logic run, rd_g, wr_g, dea_g;
    logic rd_tap, kill_tap, mask_tap, start;
    logic rd_act, wr_act;

    always_comb begin
        st_d     = st_q;
        st_d.cke = cke_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cke: 1'b1};
        else        st_q <= st_d;
    end

    // internal clock runs when enable was high one edge earlier
    assign run   = st_q.cke;
    assign rd_g  = run & cs_i & rd_cmd_i;
    assign wr_g  = run & cs_i & wr_cmd_i;
    assign dea_g = run & cs_i & deact_cmd_i;
    assign start = rd_tap & ~wr_g;

    dbl_delay #(.DEPTH(CL_MAX - 1)) u_rd_dly (
        .clk(clk), .rst_n(rst_n), .en_i(run), .clr_i(wr_g), .din_i(rd_g),
        .sel_long_i(cas_lat3_i), .tap_o(rd_tap));

    dbl_delay #(.DEPTH(CL_MAX)) u_hz_dly (
        .clk(clk), .rst_n(rst_n), .en_i(run), .clr_i(1'b0), .din_i(dea_g),
        .sel_long_i(cas_lat3_i), .tap_o(kill_tap));

    dbl_delay #(.DEPTH(RD_MASK_LAT + 1)) u_mask_dly (
        .clk(clk), .rst_n(rst_n), .en_i(run), .clr_i(1'b0), .din_i(mask_i),
        .sel_long_i(1'b1), .tap_o(mask_tap));

    dbl_burst #(.LW(LW), .MAXV(BURST_LEN - 1)) u_rd_burst (
        .clk(clk), .rst_n(rst_n), .en_i(run), .load_i(start), .load_val_i(RD_LOAD),
        .clr_i(kill_tap | wr_g), .active_o(rd_act));

    dbl_burst #(.LW(LW), .MAXV(BURST_LEN - 1)) u_wr_burst (
        .clk(clk), .rst_n(rst_n), .en_i(run), .load_i(wr_g & MULTI_BEAT), .load_val_i(WR_LOAD),
        .clr_i(rd_g | dea_g | wr_g), .active_o(wr_act));

    assign bus_drive_o = rd_act;
    assign rd_valid_o  = rd_act & ~mask_tap;
    assign wr_take_o   = run & ~mask_i & (wr_g | (wr_act & ~rd_g & ~dea_g));

    AST_VALID_NEEDS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> bus_drive_o); // R4
    AST_WR_MASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        mask_i |-> !wr_take_o); // R3
    AST_HIZ_AFTER_DEACT: assert property (@(posedge clk) disable iff (!rst_n)
        (run && kill_tap && !start) |=> !bus_drive_o); // R5
    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ($stable(bus_drive_o) && $stable(rd_valid_o))); // R9
    AST_FROZEN_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !wr_take_o); // R9
    AST_CS_BLOCKS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_i && !wr_act) |-> !wr_take_o); // R8
    AST_WR_CUTS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        wr_g |=> !bus_drive_o); // R6
endmodule

// File: tb/tb_dbl_bus_timer.sv
module tb_dbl_bus_timer;
    localparam int BL = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cas = 1'b0, cke = 1'b1, cs = 1'b1;
    logic rd = 1'b0, wr = 1'b0, dea = 1'b0, msk = 1'b0;
    logic rd_valid, bus_drive, wr_take;
    int total = 0, bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dbl_bus_timer #(.BURST_LEN(BL)) dut (
        .clk(clk), .rst_n(rst_n), .cas_lat3_i(cas), .cke_i(cke), .cs_i(cs),
        .rd_cmd_i(rd), .wr_cmd_i(wr), .deact_cmd_i(dea), .mask_i(msk),
        .rd_valid_o(rd_valid), .bus_drive_o(bus_drive), .wr_take_o(wr_take));

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rd = 0; wr = 0; dea = 0; msk = 0; cs = 1; cke = 1;
        end
    endtask

    // read at E0; optional mask edge, deactivate edge, second read edge (-1 = none)
    task automatic t_read(input logic cl3, input int m_at, input int d_at, input int r2_at, input string req);
        int lat;
        logic win, expd, expv;
        lat = cl3 ? 2 : 1;
        @(negedge clk);
        cas = cl3; rd = 1; msk = (m_at == 0); dea = (d_at == 0);
        for (int j = 0; j < 12; j++) begin
            @(posedge clk);
            @(negedge clk);
            if (r2_at >= 0)
                win = (j >= lat && j < r2_at + lat) || (j >= r2_at + lat && j <= r2_at + lat + BL - 1);
            else
                win = (j >= lat && j <= lat + BL - 1);
            expd = win && !(d_at >= 0 && j >= d_at + lat + 1);
            expv = expd && !(m_at >= 0 && j == m_at + 2);
            chk(bus_drive, expd, req, $sformatf("bus_drive edge %0d", j));
            chk(rd_valid, expv, req, $sformatf("rd_valid edge %0d", j));
            rd = (j + 1 == r2_at); msk = (j + 1 == m_at); dea = (j + 1 == d_at);
        end
        idle(2);
    endtask

    // write at cycle 0; optional mask, read, deactivate cycle (-1 = none)
    task automatic t_write(input int m_j, input int r_j, input int d_j, input string req);
        logic exp;
        for (int j = 0; j < 8; j++) begin
            @(negedge clk);
            wr = (j == 0); msk = (j == m_j); rd = (j == r_j); dea = (j == d_j);
            #1;
            exp = (j < BL) && (j != m_j) && !(r_j >= 0 && j >= r_j) && !(d_j >= 0 && j >= d_j);
            chk(wr_take, exp, req, $sformatf("wr_take cycle %0d", j));
        end
        idle(12);
    endtask

    task automatic t_cs;
        @(negedge clk);
        cs = 0; rd = 1; wr = 1;
        #1 chk(wr_take, 1'b0, "R8", "write with cs low");
        @(negedge clk);
        cs = 1; rd = 0; wr = 0;
        for (int j = 0; j < 6; j++) begin
            @(negedge clk);
            chk(bus_drive | rd_valid | wr_take, 1'b0, "R8", "read with cs low");
        end
    endtask

    task automatic t_cke_read;
        logic exp;
        @(negedge clk);
        cas = 0; rd = 1; cke = 1;
        for (int j = 0; j < 9; j++) begin
            @(posedge clk);
            @(negedge clk);
            exp = (j >= 1 && j <= 5);
            chk(rd_valid, exp, "R9", $sformatf("stretched read edge %0d", j));
            rd = 0; cke = (j + 1 != 1);
        end
        idle(2);
    endtask

    task automatic t_cke_write;
        @(negedge clk);
        cke = 0;
        @(negedge clk);
        wr = 1;
        #1 chk(wr_take, 1'b0, "R9", "write while frozen");
        @(negedge clk);
        wr = 0; cke = 1;
        for (int j = 0; j < 5; j++) begin
            @(negedge clk);
            #1 chk(wr_take, 1'b0, "R9", "no burst from frozen write");
        end
        idle(2);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(rd_valid, 1'b0, "R10", "rd_valid in reset");
        chk(bus_drive, 1'b0, "R10", "bus_drive in reset");
        chk(wr_take, 1'b0, "R10", "wr_take in reset");
        rst_n = 1;
        idle(2);
        t_read(1'b0, -1, -1, -1, "R1");   // CAS latency 2
        t_read(1'b1, -1, -1, -1, "R1");   // CAS latency 3
        t_read(1'b0, 2, -1, -1, "R4");    // read mask lands two edges later
        t_read(1'b1, 1, -1, -1, "R4");
        t_read(1'b0, -1, 1, -1, "R5");    // release after 2 edges
        t_read(1'b1, -1, 1, -1, "R5");    // release after 3 edges
        t_read(1'b0, -1, -1, 2, "R6");    // second read restarts burst
        t_write(-1, -1, -1, "R2");
        t_write(1, -1, -1, "R3");
        t_write(-1, 2, -1, "R7");
        t_write(-1, -1, 1, "R7");
        t_cs;
        t_cke_read;
        t_cke_write;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule